// File: doc/BRIEF.md
# Buffer-to-Register Transfer Router

This block moves one word between a transfer buffer and a small register file. A command is a start strobe, a direction flag and a 2-bit destination address. In the write direction, the buffer word is copied into one of four destinations: two data registers, an instruction register and a spare register. In the read direction, the buffer is loaded from data register 1. Data register 1 is the only register that can be read back. For every command, one transfer path is active and the others do nothing.

Each destination bit is set when the buffer bit is 1 and cleared when it is 0. A destination therefore always ends up equal to the buffer, whatever it held before. The buffer itself is filled from the memory side through a load port. The command is latched on the start edge and carried out on the next edge. A one-cycle done pulse follows, and it is the only completion indication for every path.

Top module: `xfer_router`

## Requirements
- R1: While `rst_n` is low, every register, the buffer, `busy` and `done` read zero.
- R2: A `start` sampled while `busy` is low sets `busy` for exactly one cycle. The transfer takes effect on the next edge, and `done` is high for exactly one cycle, the cycle in which the new value is first visible.
- R3: A write (`mode_rd`=0) with `dest_addr`=0 copies the buffer into data register 1 (`dreg1_q`).
- R4: A write with `dest_addr`=1 copies the buffer into data register 2 (`dreg2_q`).
- R5: A write with `dest_addr`=2 copies the buffer into the instruction register (`ireg_q`).
- R6: A write with `dest_addr`=3 copies the buffer into the spare register (`spare_q`).
- R7: A read (`mode_rd`=1) loads the buffer from data register 1. The address has no effect, and no destination register changes.
- R8: A write drives both 1 and 0 bits, so the destination equals the buffer word even where it previously held ones.
- R9: A transfer changes only its selected target; all other registers keep their values.
- R10: A `start` sampled while `busy` is high is ignored. No extra done pulse appears and no register changes because of it.
- R11: `buf_ld` loads `buf_d` into the buffer on the next edge when `busy` is low, and is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer command strobe |
| mode_rd | input | 1 | 1 = read data register 1 into buffer, 0 = write buffer out |
| dest_addr | input | 2 | Write destination: 0 dreg1, 1 dreg2, 2 ireg, 3 spare |
| buf_ld | input | 1 | Load buffer from memory side |
| buf_d | input | W (8) | Word for a buffer load |
| busy | output | 1 | Command latched, transfer pending |
| done | output | 1 | One-cycle completion pulse |
| buf_q | output | W (8) | Buffer contents |
| dreg1_q | output | W (8) | Data register 1 |
| dreg2_q | output | W (8) | Data register 2 |
| ireg_q | output | W (8) | Instruction register |
| spare_q | output | W (8) | Spare register |

## Verification
The bound checker checks the following on every cycle:
- the start, busy and done sequence;
- that done lasts a single cycle;
- that no register moves outside a done cycle;
- that in a done cycle the latched target equals its source and, for reads, the destinations hold.

Only the directed scenarios can show the rest:
- the actual data values that reach each address;
- that zeros overwrite ones;
- that a second start, or a buffer load arriving during the pending cycle, leaves no trace in the values that follow.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int unsigned N_DEST = 4;
  localparam int unsigned ADDR_W = $clog2(N_DEST);

  typedef enum logic [ADDR_W-1:0] {
    DST_DREG1 = 2'd0,
    DST_DREG2 = 2'd1,
    DST_IREG  = 2'd2,
    DST_SPARE = 2'd3
  } dest_e;

  typedef struct packed {
    logic  rd;
    dest_e dst;
  } xfer_cmd_t;
endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  xfer_cmd_t cmd_in,
  output logic      busy,
  output logic      go,
  output xfer_cmd_t cmd_q,
  output logic      done
);
  logic      pend_q, pend_n;
  logic      done_q, done_n;
  xfer_cmd_t cmd_n;
  logic      accept;

  assign accept = start & ~pend_q;

  always_comb begin
    pend_n = pend_q;
    done_n = 1'b0;
    cmd_n  = cmd_q;
    if (pend_q) begin
      pend_n = 1'b0;
      done_n = 1'b1;
    end else if (accept) begin
      pend_n = 1'b1;
      cmd_n  = cmd_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
      cmd_q  <= '0;
    end else begin
      pend_q <= pend_n;
      done_q <= done_n;
      cmd_q  <= cmd_n;
    end
  end

  assign busy = pend_q;
  assign go   = pend_q;
  assign done = done_q;
endmodule

// File: rtl/xfer_dec.sv
module xfer_dec
  import xfer_pkg::*;
(
  input  logic              go,
  input  xfer_cmd_t         cmd,
  output logic [N_DEST-1:0] wr_en,
  output logic              rd_en
);
  always_comb begin
    wr_en = '0;
    rd_en = 1'b0;
    if (go) begin
      if (cmd.rd) begin
        rd_en = 1'b1;
      end else begin
        wr_en[cmd.dst] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xfer_word.sv
module xfer_word #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] src,
  output logic [W-1:0] q
);
  logic [W-1:0] set_m, clr_m, q_n;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign set_m[b] = en &  src[b];
    assign clr_m[b] = en & ~src[b];
    assign q_n[b]   = (q[b] | set_m[b]) & ~clr_m[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= q_n;
    end
  end
endmodule

// File: rtl/xfer_router.sv
module xfer_router
  import xfer_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         mode_rd,
  input  logic [1:0]   dest_addr,
  input  logic         buf_ld,
  input  logic [W-1:0] buf_d,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] dreg1_q,
  output logic [W-1:0] dreg2_q,
  output logic [W-1:0] ireg_q,
  output logic [W-1:0] spare_q
);
  xfer_cmd_t         cmd_in, cmd_q;
  logic              go, rd_en, buf_en;
  logic [N_DEST-1:0] wr_en;
  logic [W-1:0]      dst_q [N_DEST];
  logic [W-1:0]      buf_src;

  assign cmd_in.rd  = mode_rd;
  assign cmd_in.dst = dest_e'(dest_addr);

  xfer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_in(cmd_in),
    .busy(busy), .go(go), .cmd_q(cmd_q), .done(done)
  );

  xfer_dec u_dec (.go(go), .cmd(cmd_q), .wr_en(wr_en), .rd_en(rd_en));

  for (genvar d = 0; d < N_DEST; d++) begin : g_dst
    xfer_word #(.W(W)) u_reg (
      .clk(clk), .rst_n(rst_n), .en(wr_en[d]), .src(buf_q), .q(dst_q[d])
    );
  end

  assign buf_en  = rd_en | (buf_ld & ~busy);
  assign buf_src = rd_en ? dst_q[DST_DREG1] : buf_d;

  xfer_word #(.W(W)) u_buf (
    .clk(clk), .rst_n(rst_n), .en(buf_en), .src(buf_src), .q(buf_q)
  );

  assign dreg1_q = dst_q[DST_DREG1];
  assign dreg2_q = dst_q[DST_DREG2];
  assign ireg_q  = dst_q[DST_IREG];
  assign spare_q = dst_q[DST_SPARE];
endmodule

// File: rtl/xfer_router_chk.sv
module xfer_router_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         mode_rd,
  input logic [1:0]   dest_addr,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] buf_q,
  input logic [W-1:0] dreg1_q,
  input logic [W-1:0] dreg2_q,
  input logic [W-1:0] ireg_q,
  input logic [W-1:0] spare_q
);
  logic       c_rd;
  logic [1:0] c_addr;
  logic [W-1:0] tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_rd   <= 1'b0;
      c_addr <= 2'd0;
    end else if (start && !busy) begin
      c_rd   <= mode_rd;
      c_addr <= dest_addr;
    end
  end

  always_comb begin
    case (c_addr)
      2'd0:    tgt = dreg1_q;
      2'd1:    tgt = dreg2_q;
      2'd2:    tgt = ireg_q;
      default: tgt = spare_q;
    endcase
  end

  assert_accept_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy ##1 (done && !busy));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  assert_quiet_regs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(dreg1_q) && $stable(dreg2_q) && $stable(ireg_q) && $stable(spare_q)));

  assert_write_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !c_rd) |-> (tgt == buf_q));

  assert_read_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && c_rd) |-> (buf_q == dreg1_q && $stable(dreg1_q) && $stable(dreg2_q)
                        && $stable(ireg_q) && $stable(spare_q)));
endmodule

bind xfer_router xfer_router_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode_rd(mode_rd),
  .dest_addr(dest_addr), .busy(busy), .done(done), .buf_q(buf_q),
  .dreg1_q(dreg1_q), .dreg2_q(dreg2_q), .ireg_q(ireg_q), .spare_q(spare_q)
);

// File: tb/test_xfer_router.sv
module test_xfer_router;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, mode_rd, buf_ld;
  logic [1:0]   dest_addr;
  logic [W-1:0] buf_d;
  logic         busy, done;
  logic [W-1:0] buf_q, dreg1_q, dreg2_q, ireg_q, spare_q;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_r [4];
  logic [W-1:0] exp_buf;

  always #5 clk = ~clk;

  xfer_router #(.W(W)) i_xfer_router (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_rd(mode_rd),
    .dest_addr(dest_addr), .buf_ld(buf_ld), .buf_d(buf_d), .busy(busy),
    .done(done), .buf_q(buf_q), .dreg1_q(dreg1_q), .dreg2_q(dreg2_q),
    .ireg_q(ireg_q), .spare_q(spare_q)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, buf_q, exp_buf);
    chk(req, dreg1_q, exp_r[0]);
    chk(req, dreg2_q, exp_r[1]);
    chk(req, ireg_q, exp_r[2]);
    chk(req, spare_q, exp_r[3]);
  endtask

  task automatic load_buf(input logic [W-1:0] v);
    @(negedge clk);
    buf_ld = 1'b1; buf_d = v;
    @(negedge clk);
    buf_ld = 1'b0;
    exp_buf = v;
    chk("R11 idle load", buf_q, v);
  endtask

  task automatic xfer(input logic rd, input logic [1:0] a, input string req);
    @(negedge clk);
    start = 1'b1; mode_rd = rd; dest_addr = a;
    @(negedge clk);
    start = 1'b0;
    chk({req, " R2 busy"}, W'(busy), W'(1));
    chk({req, " R2 no early done"}, W'(done), W'(0));
    @(negedge clk);
    if (rd) exp_buf = exp_r[0];
    else    exp_r[a] = exp_buf;
    chk({req, " R2 done"}, W'(done), W'(1));
    chk_all(req);
    @(negedge clk);
    chk({req, " R2 done one cycle"}, W'(done), W'(0));
  endtask

  task automatic t_reset;
    chk("R1 buf", buf_q, '0);
    chk("R1 regs", dreg1_q | dreg2_q | ireg_q | spare_q, '0);
    chk("R1 flags", W'({busy, done}), '0);
  endtask

  task automatic t_each_dest;
    load_buf(8'hA5); xfer(1'b0, 2'd0, "R3 R9 write dreg1");
    load_buf(8'h3C); xfer(1'b0, 2'd1, "R4 R9 write dreg2");
    load_buf(8'hC3); xfer(1'b0, 2'd2, "R5 R9 write ireg");
    load_buf(8'h7E); xfer(1'b0, 2'd3, "R6 R9 write spare");
  endtask

  task automatic t_zeros;
    load_buf(8'h00); xfer(1'b0, 2'd2, "R8 clear ireg");
    load_buf(8'h0F); xfer(1'b0, 2'd3, "R8 partial spare");
  endtask

  task automatic t_read;
    load_buf(8'h11);
    xfer(1'b1, 2'd2, "R7 read addr ignored");
    chk("R7 buf from dreg1", buf_q, 8'hA5);
  endtask

  task automatic t_busy_start;
    load_buf(8'h99);
    @(negedge clk);
    start = 1'b1; mode_rd = 1'b0; dest_addr = 2'd1;
    @(negedge clk);
    dest_addr = 2'd3;
    @(negedge clk);
    start = 1'b0;
    exp_r[1] = 8'h99;
    chk("R10 done from first", W'(done), W'(1));
    chk_all("R10 second start ignored");
    @(negedge clk);
    chk("R10 no second done", W'(done), W'(0));
    @(negedge clk);
    chk("R10 still no done", W'(done), W'(0));
    chk_all("R10 regs unchanged");
  endtask

  task automatic t_busy_load;
    load_buf(8'h44);
    @(negedge clk);
    start = 1'b1; mode_rd = 1'b0; dest_addr = 2'd0;
    @(negedge clk);
    start = 1'b0; buf_ld = 1'b1; buf_d = 8'hEE;
    @(negedge clk);
    buf_ld = 1'b0;
    exp_r[0] = 8'h44;
    chk_all("R11 load ignored while busy");
  endtask

  initial begin
    start = 0; mode_rd = 0; buf_ld = 0; dest_addr = 0; buf_d = 0;
    exp_buf = '0;
    for (int i = 0; i < 4; i++) exp_r[i] = '0;
    rst_n = 1'b0;
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_each_dest();
    t_zeros();
    t_read();
    t_busy_start();
    t_busy_load();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule